// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block reads a sixteen-key hexadecimal keypad wired as a matrix of four column lines and four row lines. The block drives one column high at a time. The row lines have pull-downs, so an idle row reads low and a pressed key on the driven column pulls its row high. The columns step round-robin on a slow scan tick that the surrounding design supplies from one shared clock domain.

When a row goes high the column stops stepping and a debounce state machine takes over. The same key must be seen on the detecting tick and on a further `DEB_TICKS` consecutive ticks. Then the block issues its code with a single-cycle valid strobe. While the key stays down the column stays frozen and every other key is ignored. Release is debounced in the same way before scanning resumes. So one physical press yields one code, and bounce on press or release yields none.

Top module: `kpad_scanner`

## Requirements
- R1: After reset `col_o` is 4'b0001 (column 0 driven), `key_code` is 0 and `key_valid` is 0.
- R2: Exactly one bit of `col_o` is high at any time, and bit c high means column c is driven. While scanning with no row high, each `scan_tick` moves the driven column from c to (c+1) mod 4. Without `scan_tick` the column never changes.
- R3: A key whose row r reads high while column c is driven has the code 4*c + r. Bit r of `row_i` is row r.
- R4: A key is accepted when it reads high on the tick that detects it and on each of the next `DEB_TICKS` ticks. `key_valid` is then high for the one clock after the clock edge of the last of those ticks, and in that same clock `key_code` shows the new code.
- R5: If the candidate key is absent on any of its confirming ticks (or a different row of that column is seen instead), no code is issued. Scanning resumes, and the column steps again from the tick after the one that aborted.
- R6: From the detecting tick until release has completed, `col_o` does not change. Presses of other keys on other columns during that time issue no code.
- R7: Release completes only when no row reads high on one tick and on the next `DEB_TICKS` ticks. A row reading high again inside that window returns the block to the held condition without a new code. The column steps again on the tick after release completes.
- R8: If several rows read high on the driven column at the same tick, the lowest-numbered row gives the code.
- R9: `key_valid` never stays high for two consecutive clocks. `key_code` keeps its value in every clock in which `key_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-clock enable at the slow scan rate |
| col_o | output | 4 | Column drive, one-hot, active-high |
| row_i | input | 4 | Row sense lines, high where a key connects to the driven column |
| key_code | output | 4 | Code of the last accepted key, 4*column + row |
| key_valid | output | 1 | One-clock strobe per accepted press |

## Verification
The hardest cases to reach are the two debounce windows interrupted one tick before they expire. The bench reads the frozen column from `col_o` and computes the exact tick count to detection and acceptance. That lets it cut a press short by a single tick, and put a re-press back on the last tick of a release window. It also presses a second key on another column while the first is held, then releases the first. This shows that the waiting key is taken up only after the full release window.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int unsigned KP_COLS = 4;
  localparam int unsigned KP_ROWS = 4;
  localparam int unsigned COL_W   = $clog2(KP_COLS);
  localparam int unsigned ROW_W   = $clog2(KP_ROWS);
  localparam int unsigned CODE_W  = COL_W + ROW_W;

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_HELD    = 2'd2,
    ST_RELEASE = 2'd3
  } kp_state_e;

  // lowest set row wins: walk from the top down so the last hit overrides
  function automatic logic [ROW_W-1:0] low_row(input logic [KP_ROWS-1:0] rows);
    logic [ROW_W-1:0] idx;
    idx = '0;
    for (int i = KP_ROWS - 1; i >= 0; i--) begin
      if (rows[i]) idx = ROW_W'(i);
    end
    return idx;
  endfunction

  // code = column * KP_ROWS + row
  function automatic logic [CODE_W-1:0] key_of(input logic [COL_W-1:0] col,
                                               input logic [ROW_W-1:0] row);
    return {col, row};
  endfunction

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] col);
    return (col == COL_W'(KP_COLS - 1)) ? '0 : col + 1'b1;
  endfunction
endpackage

// File: rtl/kpad_col_drive.sv
module kpad_col_drive
  import kpad_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  output logic [COL_W-1:0]   col_idx_o,
  output logic [KP_COLS-1:0] col_o
);
  logic [COL_W-1:0] col_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_idx_q <= '0;
    else if (step_i) col_idx_q <= next_col(col_idx_q);
  end

  assign col_idx_o = col_idx_q;

  for (genvar g = 0; g < KP_COLS; g++) begin : g_col
    assign col_o[g] = (col_idx_q == COL_W'(g));
  end

  p_one_column_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_o) == 1);

  p_step_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(col_o));
endmodule

// File: rtl/kpad_row_sense.sv
module kpad_row_sense
  import kpad_pkg::*;
(
  input  logic [KP_ROWS-1:0] row_i,
  output logic               hit_o,
  output logic [ROW_W-1:0]   row_idx_o
);
  assign hit_o     = |row_i;
  assign row_idx_o = low_row(row_i);

  always_comb begin
    if (hit_o) begin
      p_picked_row_live_r8: assert (row_i[row_idx_o]);
    end
  end
endmodule

// File: rtl/kpad_debounce.sv
module kpad_debounce
  import kpad_pkg::*;
#(
  parameter int unsigned DEB_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hit_i,
  input  logic [CODE_W-1:0] code_now_i,
  output logic              hold_o,
  output logic              accept_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o
);
  localparam int unsigned CNT_W = $clog2(DEB_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_TICKS - 1);

  kp_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic              same_key;
  logic              cnt_full;

  assign same_key = hit_i && (code_now_i == cand_q);
  assign cnt_full = (cnt_q == CNT_LAST);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cand_d   = cand_q;
    accept_o = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        ST_SCAN: if (hit_i) begin
          st_d   = ST_CONFIRM;
          cand_d = code_now_i;
          cnt_d  = '0;
        end
        ST_CONFIRM: begin
          if (!same_key) begin
            st_d  = ST_SCAN;
            cnt_d = '0;
          end else if (cnt_full) begin
            st_d     = ST_HELD;
            cnt_d    = '0;
            accept_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HELD: if (!hit_i) begin
          st_d  = ST_RELEASE;
          cnt_d = '0;
        end
        ST_RELEASE: begin
          if (hit_i) begin
            st_d  = ST_HELD;
            cnt_d = '0;
          end else if (cnt_full) begin
            st_d  = ST_SCAN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_SCAN;
      cnt_q       <= '0;
      cand_q      <= '0;
      key_code_o  <= '0;
      key_valid_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      cand_q      <= cand_d;
      key_valid_o <= accept_o;
      if (accept_o) key_code_o <= cand_q;
    end
  end

  assign hold_o = (st_q != ST_SCAN);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DEB_TICKS));

  p_valid_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |-> $past(tick_i));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o |=> !key_valid_o);

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid_o |-> $stable(key_code_o));

  p_accept_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> hit_i);
endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
  import kpad_pkg::*;
#(
  parameter int unsigned DEB_TICKS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_tick,
  output logic [kpad_pkg::KP_COLS-1:0] col_o,
  input  logic [kpad_pkg::KP_ROWS-1:0] row_i,
  output logic [kpad_pkg::CODE_W-1:0]  key_code,
  output logic                      key_valid
);
  logic [COL_W-1:0]  col_idx;
  logic [ROW_W-1:0]  row_idx;
  logic              row_hit;
  logic              hold;
  logic              col_step;
  logic              accept;
  logic [CODE_W-1:0] code_now;

  assign col_step = scan_tick && !hold && !row_hit;
  assign code_now = key_of(col_idx, row_idx);

  kpad_col_drive u_cols (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (col_step),
    .col_idx_o(col_idx),
    .col_o    (col_o)
  );

  kpad_row_sense u_rows (
    .row_i    (row_i),
    .hit_o    (row_hit),
    .row_idx_o(row_idx)
  );

  kpad_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (scan_tick),
    .hit_i      (row_hit),
    .code_now_i (code_now),
    .hold_o     (hold),
    .accept_o   (accept),
    .key_code_o (key_code),
    .key_valid_o(key_valid)
  );

  p_freeze_on_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(col_o));

  p_freeze_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && row_hit) |=> $stable(col_o));

  p_accept_while_held_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> hold);
endmodule

// File: tb/kpad_scanner_bench.sv
`timescale 1ns/1ps
module kpad_scanner_bench;
  localparam int DEB = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_tick = 1'b0;
  logic [3:0] col_o;
  logic [3:0] row_i;
  logic [3:0] key_code;
  logic       key_valid;
  logic [15:0] pressed = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kpad_scanner #(.DEB_TICKS(DEB)) u_kpad_scanner (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .col_o(col_o), .row_i(row_i), .key_code(key_code), .key_valid(key_valid)
  );

  // keypad matrix model: key 4*c+r joins column c to row r
  always_comb begin
    row_i = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (col_o[c] && pressed[c*4+r]) row_i[r] = 1'b1;
  end

  function automatic int col_of(input logic [3:0] oh);
    for (int i = 0; i < 4; i++) if (oh[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(output bit v);
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    v = key_valid;
  endtask

  // key k must already be in 'pressed'; expects acceptance on the computed tick
  task automatic press_expect(input int k, input string tag);
    int n, nval, at;
    bit v;
    n = ((k/4 - col_of(col_o) + 4) % 4) + 1 + DEB;
    nval = 0; at = 0;
    for (int i = 1; i <= n; i++) begin
      step(v);
      if (v) begin nval++; at = i; end
    end
    check(nval == 1, {tag, " R4 pulse count"}, nval, 1);
    check(at == n, {tag, " R4 accept tick"}, at, n);
    check(key_code == 4'(k), {tag, " R3 code"}, key_code, k);
  endtask

  task automatic release_expect(input logic [15:0] clr, input string tag);
    int fc, nval;
    bit v;
    pressed &= ~clr;
    fc = col_of(col_o);
    nval = 0;
    for (int i = 0; i <= DEB; i++) begin
      step(v);
      if (v) nval++;
    end
    check(nval == 0, {tag, " R7 no code in release"}, nval, 0);
    check(col_of(col_o) == fc, {tag, " R7 column frozen"}, col_of(col_o), fc);
    step(v);
    check(col_of(col_o) == (fc + 1) % 4, {tag, " R7 scan resumes"}, col_of(col_o), (fc + 1) % 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit v;
    int c0, n, nval, fc;
    logic [3:0] held_code;

    repeat (3) @(negedge clk);
    check(col_o == 4'b0001, "R1 column after reset", col_o, 1);
    check(key_code == 4'h0, "R1 code after reset", key_code, 0);
    check(key_valid == 1'b0, "R1 valid after reset", key_valid, 0);
    rst_n = 1'b1;

    // R2: no tick, no movement; then one step per tick
    repeat (20) @(negedge clk);
    check(col_o == 4'b0001, "R2 no tick no step", col_o, 1);
    c0 = col_of(col_o);
    for (int i = 1; i <= 6; i++) begin
      step(v);
      check(col_of(col_o) == (c0 + i) % 4, "R2 column step", col_of(col_o), (c0 + i) % 4);
    end

    // exhaustive sweep of all sixteen keys
    for (int k = 0; k < 16; k++) begin
      pressed = 16'(1) << k;
      press_expect(k, "sweep");
      fc = col_of(col_o);
      nval = 0;
      repeat (8) begin step(v); if (v) nval++; end
      check(nval == 0, "R6 held key no repeat", nval, 0);
      check(col_of(col_o) == fc, "R6 column frozen while held", col_of(col_o), fc);
      check(key_code == 4'(k), "R9 code kept while held", key_code, k);
      release_expect(16'(1) << k, "sweep");
    end

    // R5: press cut one tick short
    held_code = key_code;
    pressed = 16'(1) << 5;
    n = ((1 - col_of(col_o) + 4) % 4) + 1 + DEB;
    nval = 0;
    for (int i = 1; i < n; i++) begin step(v); if (v) nval++; end
    pressed = '0;
    fc = col_of(col_o);
    step(v); if (v) nval++;
    check(col_of(col_o) == fc, "R5 abort tick no step", col_of(col_o), fc);
    step(v); if (v) nval++;
    check(nval == 0, "R5 short press no code", nval, 0);
    check(col_of(col_o) == (fc + 1) % 4, "R5 scan resumes", col_of(col_o), (fc + 1) % 4);
    check(key_code == held_code, "R9 code kept after abort", key_code, held_code);

    // R8: rows 1 and 3 of column 2 together
    pressed = (16'(1) << 9) | (16'(1) << 11);
    press_expect(9, "R8 lowest row");
    release_expect(pressed, "R8");

    // R6: second key on another column while first held
    pressed = 16'(1) << 6;
    press_expect(6, "R6 first");
    pressed |= 16'(1) << 12;
    fc = col_of(col_o);
    nval = 0;
    repeat (12) begin step(v); if (v) nval++; end
    check(nval == 0, "R6 other key ignored", nval, 0);
    check(col_of(col_o) == fc, "R6 column kept", col_of(col_o), fc);
    pressed &= ~(16'(1) << 6);
    nval = 0;
    for (int i = 0; i <= DEB; i++) begin step(v); if (v) nval++; end
    check(nval == 0, "R7 release window no code", nval, 0);
    press_expect(12, "R6 second after release");

    // R7: re-press on the last tick of the release window
    pressed = '0;
    fc = col_of(col_o);
    nval = 0;
    for (int i = 0; i < DEB; i++) begin step(v); if (v) nval++; end
    pressed = 16'(1) << 12;
    repeat (6) begin step(v); if (v) nval++; end
    check(nval == 0, "R7 bounce no second code", nval, 0);
    check(col_of(col_o) == fc, "R7 held again column frozen", col_of(col_o), fc);
    check(key_code == 4'd12, "R9 code kept through bounce", key_code, 12);
    release_expect(pressed, "R7 final");

    // R9: valid is a single clock
    pressed = 16'(1) << 3;
    n = ((0 - col_of(col_o) + 4) % 4) + 1 + DEB;
    for (int i = 1; i <= n; i++) step(v);
    check(v == 1'b1, "R9 valid present", v, 1);
    @(negedge clk);
    check(key_valid == 1'b0, "R9 valid one clock", key_valid, 0);
    release_expect(pressed, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule